// File: doc/BRIEF.md
# Serial Peripheral Interrupt Generator

This block turns the status lines of a serial port and its two DMA channels into ten sticky interrupt flags and one interrupt request. Three sources follow FIFO status: the transmitter has gone idle, the transmit FIFO has room, and the receive FIFO holds data. Four sources mark a DMA buffer as finished: the transmit and receive channels each have a buffer A and a buffer B. The last three sources are single-cycle error pulses: parity, framing and receive overrun.

Every source has its own detector and its own flag. A flag stays set until software writes 1 to its bit on the clear strobe. If a source fires in the same cycle as a clear, the flag stays set. A mode input chooses how the three FIFO-status sources fire: on a rising edge, or in every cycle that the source is high. The DMA sources always fire on the falling edge of the buffer's active line.

Each flag is a two-state machine. The states are `FLG_IDLE` and `FLG_PENDING`. The transition `T_RAISE` goes from `FLG_IDLE` to `FLG_PENDING` when the detector fires. The transition `T_HOLD` keeps the machine in `FLG_PENDING` when the clear is absent or the detector fires again. The transition `T_ACK` goes from `FLG_PENDING` back to `FLG_IDLE` when the bit is cleared and the detector is quiet.

The request output is the OR of all flags masked by their enables, gated by a global enable.

Top module: `sirq_ctrl`

## Requirements
- R1: After reset all flags read 0 and `irq_o` is 0.
- R2: Flag bit positions: 0 transmitter idle, 1 transmit FIFO has room, 2 receive FIFO has data, 3 transmit DMA buffer A done, 4 transmit DMA buffer B done, 5 receive DMA buffer A done, 6 receive DMA buffer B done, 7 parity error, 8 framing error, 9 receive overrun. Within each DMA pair, index 0 of the active vector is buffer A.
- R3: With `level_mode_i`=0, a FIFO-status flag is set in the cycle after its input goes from 0 to 1. An input that stays high does not set the flag again after it has been cleared.
- R4: With `level_mode_i`=1, a FIFO-status flag is set in the cycle after any cycle in which its input is high. A clear written while the input is still high therefore leaves the flag at 1.
- R5: A DMA-done flag is set in the cycle after its active input goes from 1 to 0, whatever `level_mode_i` is. A 0-to-1 change of the active input does not set it.
- R6: An error flag is set in the cycle after a cycle in which its pulse input is high.
- R7: Flags are sticky. A flag clears in the cycle after a 1 on its bit of `clear_i`. A 0 on a bit of `clear_i` leaves that flag unchanged.
- R8: When a flag's trigger and its clear bit occur in the same cycle, the flag stays 1.
- R9: `irq_o` is 1 exactly when `global_en_i` is 1 and some flag is 1 with its `enable_i` bit also 1. It follows changes of the enables within the same cycle.
- R10: A flag is set even when its `enable_i` bit is 0, and it can be read on `flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| level_mode_i | input | 1 | 1: FIFO-status sources fire on a high level; 0: they fire on a rising edge |
| tx_idle_i | input | 1 | Transmit FIFO empty and last character shifted out |
| tx_free_i | input | 1 | Transmit FIFO not full |
| rx_avail_i | input | 1 | Receive FIFO not empty |
| tx_dma_act_i | input | 2 | Transmit DMA buffer active, [0]=A, [1]=B |
| rx_dma_act_i | input | 2 | Receive DMA buffer active, [0]=A, [1]=B |
| parity_err_i | input | 1 | Pulse: character received with a parity error |
| frame_err_i | input | 1 | Pulse: character received with a framing error |
| overrun_err_i | input | 1 | Pulse: character lost because the receive FIFO was full |
| enable_i | input | 10 | Per-source enable for the request |
| clear_i | input | 10 | Write-1-to-clear strobe for the flags |
| global_en_i | input | 1 | Global request enable |
| flags_o | output | 10 | Sticky flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The flag state is visible on `flags_o`. A detector or flag machine in the wrong state therefore shows up on the first clock edge after the stimulus: a flag that fails to rise, rises twice, or fails to clear. The bench runs a reference model that steps with the design and compares both outputs after every edge. The cases that stress the edge-detector history are a held input, a DMA active line going high and then low, and the switch between edge and level mode.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int NUM_FIFO_SRC = 3;
    localparam int DMA_BUFS     = 2;
    localparam int NUM_DMA_SRC  = 2 * DMA_BUFS;
    localparam int NUM_ERR_SRC  = 3;
    localparam int NUM_SRC      = NUM_FIFO_SRC + NUM_DMA_SRC + NUM_ERR_SRC;
    localparam int DMA_BASE     = NUM_FIFO_SRC;
    localparam int ERR_BASE     = DMA_BASE + NUM_DMA_SRC;

    typedef enum logic [1:0] {
        TRIG_RISE_OR_LEVEL,
        TRIG_FALL,
        TRIG_PULSE
    } trig_kind_e;

    typedef enum logic {
        FLG_IDLE,
        FLG_PENDING
    } flag_state_e;

    function automatic trig_kind_e kind_of(int idx);
        if (idx < DMA_BASE)      return TRIG_RISE_OR_LEVEL;
        else if (idx < ERR_BASE) return TRIG_FALL;
        else                     return TRIG_PULSE;
    endfunction
endpackage

// File: rtl/sirq_trigger.sv
module sirq_trigger
    import sirq_pkg::*;
#(
    parameter trig_kind_e KIND = TRIG_PULSE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_mode_i,
    input  logic sig_i,
    output logic trig_o
);
    generate
        if (KIND == TRIG_RISE_OR_LEVEL) begin : g_rise
            logic prev_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= sig_i;
            end
            always_comb begin
                if (level_mode_i) trig_o = sig_i;
                else              trig_o = sig_i & ~prev_q;
            end
            // R4: in level mode a high input always fires
            p_level_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (level_mode_i && sig_i) |-> trig_o);
        end else if (KIND == TRIG_FALL) begin : g_fall
            logic prev_q;
            logic unused_mode;
            assign unused_mode = level_mode_i;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= sig_i;
            end
            assign trig_o = ~sig_i & prev_q;
            // R5: a DMA-done trigger needs the active line high one cycle earlier
            p_fall_history_r5: assert property (@(posedge clk) disable iff (!rst_n)
                trig_o |-> ($past(sig_i) && !sig_i));
        end else begin : g_pulse
            logic [2:0] unused_pins;
            assign unused_pins = {clk, rst_n, level_mode_i};
            assign trig_o = sig_i;
        end
    endgenerate
endmodule

// File: rtl/sirq_flag.sv
module sirq_flag
    import sirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE:    if (trig_i) state_d = FLG_PENDING;             // T_RAISE
            FLG_PENDING: if (clr_i && !trig_i) state_d = FLG_IDLE;      // T_ACK, else T_HOLD
            default:     state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FLG_PENDING);
    end

    // R8: a trigger always leaves the flag set, clear or not
    p_trigger_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> flag_o);
    // R7: without a clear the flag stays set
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    // R7: a clear without a trigger drops the flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !trig_i) |=> !flag_o);
endmodule

// File: rtl/sirq_combine.sv
module sirq_combine #(
    parameter int N = 10
) (
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] enable_i,
    input  logic         global_en_i,
    output logic         irq_o
);
    logic [N-1:0] masked;
    always_comb begin
        masked = flags_i & enable_i;
        irq_o  = global_en_i & (|masked);
    end
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
    import sirq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   level_mode_i,
    input  logic                   tx_idle_i,
    input  logic                   tx_free_i,
    input  logic                   rx_avail_i,
    input  logic [DMA_BUFS-1:0]    tx_dma_act_i,
    input  logic [DMA_BUFS-1:0]    rx_dma_act_i,
    input  logic                   parity_err_i,
    input  logic                   frame_err_i,
    input  logic                   overrun_err_i,
    input  logic [NUM_SRC-1:0]     enable_i,
    input  logic [NUM_SRC-1:0]     clear_i,
    input  logic                   global_en_i,
    output logic [NUM_SRC-1:0]     flags_o,
    output logic                   irq_o
);
    logic [NUM_SRC-1:0] src;
    logic [NUM_SRC-1:0] trig;

    assign src = {overrun_err_i, frame_err_i, parity_err_i,
                  rx_dma_act_i, tx_dma_act_i,
                  rx_avail_i, tx_free_i, tx_idle_i};

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            localparam trig_kind_e K = kind_of(i);
            sirq_trigger #(.KIND(K)) u_trig (
                .clk          (clk),
                .rst_n        (rst_n),
                .level_mode_i (level_mode_i),
                .sig_i        (src[i]),
                .trig_o       (trig[i])
            );
            sirq_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .trig_i (trig[i]),
                .clr_i  (clear_i[i]),
                .flag_o (flags_o[i])
            );
        end
    endgenerate

    sirq_combine #(.N(NUM_SRC)) u_comb (
        .flags_i     (flags_o),
        .enable_i    (enable_i),
        .global_en_i (global_en_i),
        .irq_o       (irq_o)
    );

    // R9: no request without the global enable
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> global_en_i);
    // R6: an error pulse always yields its flag next cycle
    p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err_i |=> flags_o[ERR_BASE]);
endmodule

// File: tb/sirq_ctrl_tb.sv
`timescale 1ns/1ps
module sirq_ctrl_tb;
    localparam int N = 10;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic level_mode_i = 1'b0;
    logic tx_idle_i = 1'b0, tx_free_i = 1'b0, rx_avail_i = 1'b0;
    logic [1:0] tx_dma_act_i = 2'b00, rx_dma_act_i = 2'b00;
    logic parity_err_i = 1'b0, frame_err_i = 1'b0, overrun_err_i = 1'b0;
    logic [N-1:0] enable_i = '0, clear_i = '0;
    logic global_en_i = 1'b0;
    logic [N-1:0] flags_o;
    logic irq_o;

    int tests = 0, fails = 0;
    bit done = 0;
    bit [N-1:0] m_flag = '0, m_prev = '0;

    always #10 clk = ~clk;

    sirq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .level_mode_i(level_mode_i),
        .tx_idle_i(tx_idle_i), .tx_free_i(tx_free_i), .rx_avail_i(rx_avail_i),
        .tx_dma_act_i(tx_dma_act_i), .rx_dma_act_i(rx_dma_act_i),
        .parity_err_i(parity_err_i), .frame_err_i(frame_err_i),
        .overrun_err_i(overrun_err_i), .enable_i(enable_i), .clear_i(clear_i),
        .global_en_i(global_en_i), .flags_o(flags_o), .irq_o(irq_o)
    );

    function automatic bit [N-1:0] src_vec();
        return {overrun_err_i, frame_err_i, parity_err_i, rx_dma_act_i,
                tx_dma_act_i, rx_avail_i, tx_free_i, tx_idle_i};
    endfunction

    task automatic compare(string tag);
        bit exp_irq;
        exp_irq = global_en_i && ((m_flag & enable_i) != 0);
        tests++;
        if (flags_o !== m_flag || irq_o !== exp_irq) begin
            fails++;
            $display("FAIL %s: flags=%b irq=%b expected flags=%b irq=%b",
                     tag, flags_o, irq_o, m_flag, exp_irq);
        end
    endtask

    // inputs are set at a falling edge; model steps, clock rises, compare at next fall
    task automatic cycle(string tag);
        bit [N-1:0] s;
        s = src_vec();
        for (int i = 0; i < N; i++) begin
            bit t;
            if (i < 3)      t = level_mode_i ? s[i] : (s[i] & ~m_prev[i]);
            else if (i < 7) t = ~s[i] & m_prev[i];
            else            t = s[i];
            m_flag[i] = (m_flag[i] & ~clear_i[i]) | t;
        end
        m_prev = s;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic clr(bit [N-1:0] bits, string tag);
        clear_i = bits;
        cycle(tag);
        clear_i = '0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset state");
        cycle("R1 idle after reset");
        enable_i = '1; global_en_i = 1'b1;

        // R3 edge mode on FIFO sources, bit mapping R2
        tx_idle_i = 1; cycle("R3 rise sets bit0 (R2)");
        cycle("R3 held high");
        clr(10'b1, "R3 clear while held high stays clear");
        cycle("R3 no refire while held");
        rx_avail_i = 1; tx_free_i = 1; cycle("R2 bits 1,2 set on rise");
        clr(10'b110, "R7 clear bits 1 and 2");
        tx_idle_i = 0; rx_avail_i = 0; tx_free_i = 0; cycle("R3 falling no effect");

        // R4 level mode
        level_mode_i = 1; tx_free_i = 1; cycle("R4 level fires");
        clr(10'b10, "R4 clear while high refires");
        tx_free_i = 0; cycle("R4 low");
        clr(10'b10, "R4 clear after low");
        rx_avail_i = 1; cycle("R4 level bit2");
        rx_avail_i = 0; clr(10'b100, "R4 clear bit2");

        // R5 DMA falling edges, in both modes
        tx_dma_act_i = 2'b01; cycle("R5 rise no set");
        tx_dma_act_i = 2'b00; cycle("R5 fall sets bit3");
        level_mode_i = 0;
        rx_dma_act_i = 2'b10; tx_dma_act_i = 2'b10; cycle("R5 rise B no set");
        cycle("R5 held");
        rx_dma_act_i = 2'b00; tx_dma_act_i = 2'b00; cycle("R5 fall bits 4 and 6");
        rx_dma_act_i = 2'b01; cycle("R5 rise rx A");
        rx_dma_act_i = 2'b00; cycle("R5 fall bit5");
        clr(10'b1111000, "R7 clear DMA flags");

        // R6 error pulses
        parity_err_i = 1; cycle("R6 parity");
        parity_err_i = 0; frame_err_i = 1; cycle("R6 frame");
        frame_err_i = 0; overrun_err_i = 1; cycle("R6 overrun");
        overrun_err_i = 0; cycle("R7 sticky after pulses");

        // R7 zeros in clear do nothing, R8 set beats clear
        clr(10'b0, "R7 zero clear no effect");
        clr(10'b0010000000, "R7 clear only parity");
        parity_err_i = 1; clear_i = 10'b0010000000; cycle("R8 set wins over clear");
        parity_err_i = 0; clear_i = '0; cycle("R8 still set");

        // R9 gating, R10 disabled capture
        enable_i = 10'b0010000000; #1 compare("R9 single enable");
        global_en_i = 0; #1 compare("R9 global off");
        global_en_i = 1; enable_i = '0; #1 compare("R9 all disabled");
        clr('1, "R7 clear all");
        tx_idle_i = 1; cycle("R10 disabled source still flags");
        enable_i = 10'b1; #1 compare("R9 enable pending flag raises irq");
        tx_idle_i = 0; clr('1, "R9 irq drops after clear");
        cycle("R1 quiet");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule